// File: doc/BRIEF.md
# Fixed-Point Reciprocal Square Root Unit

This block takes a positive fixed-point operand in a 16-bit two's complement word (5 integer bits including the sign, 11 fraction bits) and returns an approximation of one over its square root. The result comes out as an unsigned 16-bit word with 11 fraction bits. It is meant for small matrix factorizations in a receiver datapath, such as triangular factorization and orthogonalization, where a division by a square root is replaced by a multiply with the reciprocal root.

A priority encoder finds the most significant set bit. The operand is shifted so that this bit is the leading one, which gives a mantissa m in [1,2). The exponent offset alpha is measured from the binary point, so it is negative for operands above 1.0. A small bank of straight-line segments approximates 1/sqrt(m), or sqrt(2)/sqrt(m) when alpha is odd. Each segment slope is built from at most three signed power-of-two terms, so the unit has no multiplier and no lookup memory. The line value is then scaled by 2^floor(alpha/2) through a shifter that moves left or right depending on the sign of that exponent.

One parameter sets the number of lines and so the accuracy. A second parameter restricts the unit to operands in (0, 1.0], which is enough for triangular factorization. The operand and the result are each held in a register, and a valid bit travels alongside the data.

Top module: `isqrt_unit`

## Requirements
- R1: While rst_n is low, out_valid, out_err and out_y are all 0.
- R2: An operand presented with in_valid high at a rising edge produces out_valid high after the second rising edge that follows. A cycle with in_valid low produces out_valid low at the same point.
- R3: A zero operand (code 0x0000) gives out_err = 1 and out_y = 0xFFFF.
- R4: A negative operand (bit 15 set) gives out_err = 1 and out_y = 0xFFFF.
- R5: For a positive operand whose true result is below 32.0, out_y read as unsigned Q5.11 is within 3.1 % + 4 LSB of 1/sqrt(x). This holds for the default of 3 line bits, which gives 8 segments.
- R6: Operands that are even powers of two give exact results: 1.0 -> 1.0, 4.0 -> 0.5, 0.25 -> 2.0, 1/16 -> 4.0, 1/64 -> 8.0, 1/256 -> 16.0.
- R7: When the true result is at least 32.0 (codes 0x0001 and 0x0002), out_y saturates to 0xFFFF with out_err = 0.
- R8: out_err is high only together with out_valid, and it stays low for every positive operand in full-range mode.
- R9: With the subunitary option, any operand above 1.0 (code > 0x0800) is flagged like R3. An operand in (0, 1.0] gives the same result as the full-range unit.
- R10: The unit accepts one operand per cycle, back to back, and returns results in the order the operands arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand on in_x is valid this cycle |
| in_x | input | 16 | Operand, signed Q5.11 |
| out_valid | output | 1 | Result on out_y is valid |
| out_y | output | 16 | Result, unsigned Q5.11, saturated to 0xFFFF |
| out_err | output | 1 | Operand was zero, negative or out of range |

## Verification
The assertions assume that rst_n is held low until the clock is running. They also assume that in_valid and in_x are clean 0/1 values at every sampled edge, so the two-cycle valid relation and the zero and negative checks only ever see defined operands. The stimulus drives in_valid and in_x on the falling edge from reset onward, and it never leaves them unknown. The core-range check assumes the normalized mantissa always has its leading one set. The stimulus reaches every positive code, both saturating codes and several negative codes, so both the error path and the normal path are exercised under that assumption.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    // Integer square root of a non-negative 64-bit value, bit by bit.
    function automatic longint isqrt64(input longint v);
        longint rem;
        longint root;
        longint bitv;
        rem  = v;
        root = 0;
        bitv = 64'sh4000_0000_0000_0000;
        while (bitv > rem) bitv = bitv >> 2;
        while (bitv != 0) begin
            if (rem >= root + bitv) begin
                rem  = rem - (root + bitv);
                root = (root >> 1) + bitv;
            end else begin
                root = root >> 1;
            end
            bitv = bitv >> 2;
        end
        return root;
    endfunction

    // Value of (odd ? sqrt(2) : 1) / sqrt(1 + idx/nseg), scaled by 2^cf.
    function automatic int line_point(input int idx, input int nseg, input int odd, input int cf);
        longint num;
        num = (longint'((odd != 0) ? 2 : 1) * longint'(nseg)) << (2 * cf);
        return int'(isqrt64(num / longint'(nseg + idx)));
    endfunction

    // Chord slope magnitude over one segment, per unit of mantissa, scaled by 2^cf.
    function automatic int line_slope(input int seg, input int nseg, input int odd, input int cf);
        return (line_point(seg, nseg, odd, cf) - line_point(seg + 1, nseg, odd, cf)) * nseg;
    endfunction

    // Greedy signed power-of-two split of a slope. Term j is coded as
    // sign*(e+1), meaning sign*2^-e; 0 means the term is absent.
    function automatic int term_code(input int slope, input int j, input int cf);
        int r;
        int code;
        int s;
        int mag;
        int best_e;
        int best_err;
        int p;
        int err;
        r    = slope;
        code = 0;
        for (int step = 0; step <= j; step++) begin
            code = 0;
            if (r != 0) begin
                s        = (r > 0) ? 1 : -1;
                mag      = (r > 0) ? r : -r;
                best_e   = 0;
                best_err = 32'h3fff_ffff;
                for (int e = 0; e <= cf; e++) begin
                    p   = 1 << (cf - e);
                    err = (mag > p) ? (mag - p) : (p - mag);
                    if (err < best_err) begin
                        best_err = err;
                        best_e   = e;
                    end
                end
                code = s * (best_e + 1);
                r    = r - s * (1 << (cf - best_e));
            end
        end
        return code;
    endfunction

endpackage

// File: rtl/isqrt_norm.sv
module isqrt_norm #(
    parameter int W   = 16,
    localparam int LZW = $clog2(W + 1)
) (
    input  logic [W-1:0]   x_i,
    output logic [LZW-1:0] lz_o,
    output logic [W-1:0]   mant_o,
    output logic           zero_o
);

    // Priority encoder: the highest set bit wins because it is visited last.
    always_comb begin
        lz_o = LZW'(W);
        for (int i = 0; i < W; i++) begin
            if (x_i[i]) lz_o = LZW'(W - 1 - i);
        end
    end

    assign mant_o = x_i << lz_o;
    assign zero_o = (x_i == '0);

endmodule

// File: rtl/isqrt_pwl.sv
module isqrt_pwl import isqrt_pkg::*; #(
    parameter int FW        = 15,
    parameter int LINE_BITS = 3,
    localparam int YW   = FW + 2,
    localparam int SEGB = LINE_BITS - 1,
    localparam int NSEG = 1 << SEGB,
    localparam int NL   = 1 << LINE_BITS,
    localparam int DW   = FW - SEGB
) (
    input  logic [FW-1:0] frac_i,
    input  logic          odd_i,
    output logic [YW-1:0] y_o
);

    logic [DW-1:0]        dfrac;
    logic [LINE_BITS-1:0] sel;
    logic signed [YW-1:0] line_y [NL];

    assign dfrac = frac_i[DW-1:0];

    if (SEGB > 0) begin : g_seg
        assign sel = {frac_i[FW-1 -: SEGB], odd_i};
    end else begin : g_noseg
        assign sel = odd_i;
    end

    for (genvar t = 0; t < NL; t++) begin : g_line
        localparam int SEG = t >> 1;
        localparam int ODD = t & 1;
        localparam int A   = line_point(SEG, NSEG, ODD, FW);
        localparam int B   = line_slope(SEG, NSEG, ODD, FW);
        logic signed [YW-1:0] term [3];

        for (genvar j = 0; j < 3; j++) begin : g_term
            localparam int CJ = term_code(B, j, FW);
            localparam int EJ = (CJ < 0) ? (-CJ - 1) : ((CJ > 0) ? (CJ - 1) : 0);
            logic signed [YW-1:0] mag;
            assign mag = YW'(dfrac >> EJ);
            if (CJ > 0) begin : g_pos
                assign term[j] = mag;
            end else if (CJ < 0) begin : g_neg
                assign term[j] = -mag;
            end else begin : g_zero
                assign term[j] = '0;
            end
        end

        assign line_y[t] = YW'(A) - term[0] - term[1] - term[2];
    end

    assign y_o = line_y[sel];

endmodule

// File: rtl/isqrt_scale.sv
module isqrt_scale #(
    parameter int YW       = 17,
    parameter int CF       = 15,
    parameter int OUT_W    = 16,
    parameter int OUT_FRAC = 11,
    parameter int K_MIN    = -2,
    parameter int K_MAX    = 5,
    parameter int KW       = 8,
    localparam int SH_MIN = K_MIN - (CF - OUT_FRAC),
    localparam int SH_MAX = K_MAX - (CF - OUT_FRAC),
    localparam int NSH    = SH_MAX - SH_MIN + 1,
    localparam int LSH    = (SH_MAX > 0) ? SH_MAX : 0,
    localparam int WW     = YW + LSH
) (
    input  logic [YW-1:0]        y_i,
    input  logic signed [KW-1:0] k_i,
    output logic [OUT_W-1:0]     res_o,
    output logic                 ovf_o
);

    logic [WW-1:0] cand [NSH];

    // One hardwired shift for each reachable exponent.
    for (genvar i = 0; i < NSH; i++) begin : g_sh
        localparam int AMT = SH_MIN + i;
        if (AMT >= 0) begin : g_left
            assign cand[i] = WW'(y_i) << AMT;
        end else begin : g_right
            assign cand[i] = WW'(y_i >> (-AMT));
        end
    end

    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        for (int i = 0; i < NSH; i++) begin
            if (int'(k_i) - (CF - OUT_FRAC) == SH_MIN + i) begin
                res_o = cand[i][OUT_W-1:0];
                ovf_o = |cand[i][WW-1:OUT_W];
            end
        end
    end

endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit #(
    parameter int IN_W       = 16,
    parameter int IN_FRAC    = 11,
    parameter int OUT_W      = 16,
    parameter int OUT_FRAC   = 11,
    parameter int LINE_BITS  = 3,
    parameter bit FULL_RANGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_x,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_y,
    output logic             out_err
);

    localparam int LZW    = $clog2(IN_W + 1);
    localparam int IWL_M1 = IN_W - 1 - IN_FRAC;
    localparam int FW     = IN_W - 1;
    localparam int YW     = FW + 2;
    localparam int KW     = 8;
    localparam int A_MIN  = FULL_RANGE ? (1 - IWL_M1) : 0;
    localparam int A_MAX  = IN_W - 1 - IWL_M1;
    localparam int K_MIN  = A_MIN >>> 1;
    localparam int K_MAX  = A_MAX >>> 1;
    localparam logic [IN_W-1:0] ONE_CODE = IN_W'(1) << IN_FRAC;
    localparam int Y_LO   = (1 << FW) * 2 / 3;
    localparam int Y_HI   = (1 << FW) * 3 / 2;

    typedef struct packed {
        logic            vld;
        logic [IN_W-1:0] x;
    } in_stage_t;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [OUT_W-1:0] y;
    } out_stage_t;

    typedef struct packed {
        in_stage_t  in_s;
        out_stage_t out_s;
    } state_t;

    state_t st_d, st_q;

    logic [LZW-1:0]       lz;
    logic [IN_W-1:0]      mant;
    logic                 is_zero;
    logic signed [KW-1:0] alpha;
    logic signed [KW-1:0] kexp;
    logic [YW-1:0]        core_y;
    logic [OUT_W-1:0]     scaled;
    logic                 ovf;
    logic                 bad_in;

    isqrt_norm #(.W(IN_W)) u_norm (
        .x_i    (st_q.in_s.x),
        .lz_o   (lz),
        .mant_o (mant),
        .zero_o (is_zero)
    );

    // alpha counts zeros past the binary point; negative above 1.0
    assign alpha = $signed(KW'(lz)) - $signed(KW'(IWL_M1));
    assign kexp  = alpha >>> 1;

    isqrt_pwl #(.FW(FW), .LINE_BITS(LINE_BITS)) u_pwl (
        .frac_i (mant[FW-1:0]),
        .odd_i  (alpha[0]),
        .y_o    (core_y)
    );

    isqrt_scale #(
        .YW(YW), .CF(FW), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC),
        .K_MIN(K_MIN), .K_MAX(K_MAX), .KW(KW)
    ) u_scale (
        .y_i   (core_y),
        .k_i   (kexp),
        .res_o (scaled),
        .ovf_o (ovf)
    );

    assign bad_in = is_zero | st_q.in_s.x[IN_W-1] |
                    ((FULL_RANGE == 1'b0) && (st_q.in_s.x > ONE_CODE));

    always_comb begin
        st_d = st_q;
        st_d.in_s.vld  = in_valid;
        st_d.in_s.x    = in_valid ? in_x : st_q.in_s.x;
        st_d.out_s.vld = st_q.in_s.vld;
        if (st_q.in_s.vld) begin
            st_d.out_s.err = bad_in;
            st_d.out_s.y   = (bad_in || ovf) ? '1 : scaled;
        end else begin
            st_d.out_s.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_s.vld;
    assign out_y     = st_q.out_s.y;
    assign out_err   = st_q.out_s.err;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R3 R4
    bad_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((in_x == '0) || in_x[IN_W-1])) |=> ##1 (out_err && (&out_y)));

    // R8
    err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);

    // R5
    norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_s.vld && !is_zero) |-> mant[IN_W-1]);

    // R5
    core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_s.vld && !bad_in) |-> ((int'(core_y) >= Y_LO) && (int'(core_y) <= Y_HI)));

    if (FULL_RANGE == 1'b0) begin : g_sub_chk
        // R9
        range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_x[IN_W-1] && (in_x > ONE_CODE)) |=> ##1 out_err);
    end

endmodule

// File: tb/tb_isqrt_unit.sv
module tb_isqrt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_x = 16'h0000;
    logic        out_valid, out_err, s_valid, s_err;
    logic [15:0] out_y, s_y;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    isqrt_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(out_valid), .out_y(out_y), .out_err(out_err)
    );

    isqrt_unit #(.FULL_RANGE(1'b0)) dut_sub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(s_valid), .out_y(s_y), .out_err(s_err)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Checks one result slot against the requirements for operand x.
    task automatic check_sample(input logic [15:0] x, input bit vexp);
        real ref_v;
        real tol;
        real diff;
        check_eq("R2 out_valid", int'(out_valid), int'(vexp));
        if (!vexp) begin
            check_eq("R8 err while idle", int'(out_err), 0);
        end else if (x == 16'h0000 || x[15]) begin
            check_eq("R3/R4 err flag", int'(out_err), 1);
            check_eq("R3/R4 max code", int'(out_y), 16'hFFFF);
        end else begin
            ref_v = 2048.0 / $sqrt(real'(x) / 2048.0);
            check_eq("R8 no err", int'(out_err), 0);
            if (ref_v >= 65535.5) begin
                check_eq("R7 saturate", int'(out_y), 16'hFFFF);
            end else begin
                tol  = 0.031 * ref_v + 4.0;
                diff = real'(out_y) - ref_v;
                if (diff < 0.0) diff = -diff;
                n_run++;
                if (diff > tol) begin
                    n_fail++;
                    $display("FAIL R5 x=%h: got %0d expected %0d", x, out_y, int'(ref_v));
                end
            end
        end
    endtask

    // Streams operands, one per cycle, and checks each slot two cycles later.
    task automatic run_stream(input logic [15:0] xs[$], input bit vs[$]);
        logic [15:0] h0 = 16'h0, h1 = 16'h0;
        bit          hv0 = 1'b0, hv1 = 1'b0;
        bit          act0 = 1'b0, act1 = 1'b0;
        for (int c = 0; c < xs.size() + 2; c++) begin
            @(negedge clk);
            if (act1) check_sample(h1, hv1);
            h1 = h0; hv1 = hv0; act1 = act0;
            if (c < xs.size()) begin
                in_valid = vs[c];
                in_x     = xs[c];
                h0 = xs[c]; hv0 = vs[c]; act0 = 1'b1;
            end else begin
                in_valid = 1'b0;
                act0 = 1'b0;
            end
        end
    endtask

    // Single operand, result read two cycles later.
    task automatic apply_one(input logic [15:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = x;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_eq("R1 out_valid", int'(out_valid), 0);
        check_eq("R1 out_err", int'(out_err), 0);
        check_eq("R1 out_y", int'(out_y), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_powers();
        logic [15:0] xs [6] = '{16'h0800, 16'h2000, 16'h0200, 16'h0080, 16'h0020, 16'h0008};
        int          ys [6] = '{2048, 1024, 4096, 8192, 16384, 32768};
        for (int i = 0; i < 6; i++) begin
            apply_one(xs[i]);
            check_eq("R6 exact power", int'(out_y), ys[i]);
            check_eq("R6 no err", int'(out_err), 0);
            check_eq("R2 valid single", int'(out_valid), 1);
        end
    endtask

    task automatic t_bad();
        logic [15:0] xs [4] = '{16'h0000, 16'h8000, 16'hFFFF, 16'h9234};
        for (int i = 0; i < 4; i++) begin
            apply_one(xs[i]);
            check_sample(xs[i], 1'b1);
        end
    endtask

    task automatic t_saturate();
        logic [15:0] xs [3] = '{16'h0001, 16'h0002, 16'h0003};
        for (int i = 0; i < 3; i++) begin
            apply_one(xs[i]);
            check_sample(xs[i], 1'b1);
        end
    endtask

    task automatic t_bubbles();
        logic [15:0] xs[$] = '{16'h0800, 16'h1234, 16'h0000, 16'h7FFF, 16'h0100,
                               16'h0555, 16'hC000, 16'h0003, 16'h4000};
        bit vs[$] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
        run_stream(xs, vs);   // R2 R10
    endtask

    task automatic t_sweep();
        logic [15:0] xs[$];
        bit vs[$];
        for (int v = 1; v < 32768; v++) begin
            xs.push_back(16'(v));
            vs.push_back(1'b1);
        end
        run_stream(xs, vs);   // R5 R7 R8 R10
    endtask

    task automatic t_subunitary();
        logic [15:0] bad [3] = '{16'h0801, 16'h7FFF, 16'h1000};
        logic [15:0] ok  [4] = '{16'h0800, 16'h0400, 16'h0123, 16'h0001};
        for (int i = 0; i < 3; i++) begin
            apply_one(bad[i]);
            check_eq("R9 over range err", int'(s_err), 1);
            check_eq("R9 over range code", int'(s_y), 16'hFFFF);
        end
        for (int i = 0; i < 4; i++) begin
            apply_one(ok[i]);
            check_eq("R9 in range match", int'(s_y), int'(out_y));
            check_eq("R9 in range no err", int'(s_err), 0);
            check_eq("R9 valid", int'(s_valid), 1);
        end
    endtask

    initial begin
        t_reset();
        t_powers();
        t_bad();
        t_saturate();
        t_bubbles();
        t_subunitary();
        t_sweep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule